// File: doc/BRIEF.md
# Idle-Framed Packet Stream Decoder

This block sits behind a character decoder and word aligner on a serial receive lane. Each cycle that `in_valid` is high it takes one 32-bit double word together with four K-character flags, one for each byte. It sorts the double word into one of four kinds: idle filler, opcode carrier, plain data, or a malformed word. Idle filler is dropped. An opcode word yields a 16-bit opcode on a separate output for one cycle. A data double word is split into two 16-bit words that leave on one output in two consecutive cycles. All results come out of registers one clock after the input edge.

Packets are the runs of data double words between idles or opcodes. The block marks the first 16-bit word of each packet. When a packet closes, it compares the number of 16-bit words it carried with the programmed length `cfg_pkt_len` (the usual setting is 5000). Malformed words set a sticky error flag and are counted. Packets started and length mismatches are also counted. All counters stop at their maximum value.

Byte lanes are named in transmit order: lane 0 is `in_data[31:24]` with flag `in_kflag[3]`, and lane 3 is `in_data[7:0]` with flag `in_kflag[0]`. Because each data double word takes two output cycles, the source must leave at least one cycle with `in_valid` low between two valid double words. A lane that outputs one double word every two clocks meets this rule.

Top module: `idle_frame_decoder`

## Requirements
- R1: After reset, `wrd_valid`, `wrd_first`, `op_valid` and `frame_err` are 0, and `err_count`, `len_mismatch_count` and `pkt_count` are 0.
- R2: An idle double word has `in_kflag` = 4'b1111 and `in_data` = 32'hBC1CBC1C, which is K28.5, K28.0, K28.5, K28.0 in lanes 0 to 3. It produces no word output and no opcode output.
- R3: A data double word has `in_kflag` = 4'b0000. One cycle after the input edge, `wrd_valid` is 1 with `wrd_data` = `in_data[31:16]`. In the next cycle, `wrd_valid` is 1 with `wrd_data` = `in_data[15:0]`.
- R4: `wrd_first` is 1 only with the upper half of the first data double word after reset, after an idle, or after an opcode. It is 0 for all other words, and a malformed word between two data double words does not set it.
- R5: An opcode double word has `in_kflag` = 4'b1000 and `in_data[31:24]` = 8'hFD (K29.7). One cycle after the input edge, `op_valid` pulses for exactly one cycle with `op_data` = `in_data[23:8]`. No word output is produced.
- R6: Any other valid double word is malformed. It is dropped without any word or opcode output. It sets the sticky `frame_err` and increments `err_count`.
- R7: When an idle or opcode closes an open packet, `len_mismatch_count` increments by one if the number of 16-bit words in that packet differs from `cfg_pkt_len`. It does not change if the two are equal.
- R8: `pkt_count` increments by one at the first data double word of each packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Double word on in_data/in_kflag is present |
| in_data | input | 32 | Decoded double word, lane 0 in bits 31:24 |
| in_kflag | input | 4 | K flag per lane, bit 3 for lane 0 |
| cfg_pkt_len | input | 24 | Expected packet length in 16-bit words |
| wrd_valid | output | 1 | wrd_data carries a 16-bit data word |
| wrd_data | output | 16 | 16-bit data word, upper half first |
| wrd_first | output | 1 | Current word is the first of a packet |
| op_valid | output | 1 | One-cycle opcode strobe |
| op_data | output | 16 | Opcode payload, lanes 1 and 2 |
| frame_err | output | 1 | Sticky malformed-word flag |
| err_count | output | 16 | Malformed double words seen, saturating |
| len_mismatch_count | output | 16 | Packets closed at the wrong length, saturating |
| pkt_count | output | 16 | Packets started, saturating |

## Verification
A wrong packet-open state shows up within one cycle of the next data double word: `wrd_first` is missing or appears when it should not. The same error shows up at the closing idle as a wrong step in `pkt_count` or `len_mismatch_count`. A fault in the half-word holding register shows as a wrong or missing lower half exactly two cycles after the input edge. A wrong length accumulator only becomes visible when the packet closes, so every packet test checks the mismatch counter right after the closing idle or opcode. A misclassified double word shows one cycle later, as a spurious word, a spurious opcode or a spurious error count.

// File: rtl/pktdec_pkg.sv
package pktdec_pkg;

  typedef enum logic [1:0] {
    DW_IDLE   = 2'd0,
    DW_DATA   = 2'd1,
    DW_OPCODE = 2'd2,
    DW_BAD    = 2'd3
  } dw_kind_e;

  localparam logic [7:0]  K28_5_CHAR = 8'hBC;
  localparam logic [7:0]  K28_0_CHAR = 8'h1C;
  localparam logic [7:0]  K29_7_CHAR = 8'hFD;
  localparam logic [31:0] IDLE_DWORD = {K28_5_CHAR, K28_0_CHAR, K28_5_CHAR, K28_0_CHAR};

endpackage

// File: rtl/pktdec_classify.sv
module pktdec_classify
  import pktdec_pkg::*;
(
  input  logic [31:0] dword,
  input  logic [3:0]  kflag,
  output dw_kind_e    kind
);

  logic idle_hit;
  logic op_hit;
  logic data_hit;

  always_comb begin
    idle_hit = (kflag == 4'b1111) && (dword == IDLE_DWORD);
    op_hit   = (kflag == 4'b1000) && (dword[31:24] == K29_7_CHAR);
    data_hit = (kflag == 4'b0000);
    if (idle_hit)      kind = DW_IDLE;
    else if (op_hit)   kind = DW_OPCODE;
    else if (data_hit) kind = DW_DATA;
    else               kind = DW_BAD;
  end

endmodule

// File: rtl/pktdec_split.sv
module pktdec_split #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2*HALF_W-1:0] dword,
  input  logic                first_in,
  input  logic                in_valid,
  output logic                out_valid,
  output logic [HALF_W-1:0]   out_data,
  output logic                out_first
);

  logic [HALF_W-1:0] lo_q, lo_d;
  logic              pend_q, pend_d;
  logic              vld_q, vld_d;
  logic [HALF_W-1:0] dat_q, dat_d;
  logic              fst_q, fst_d;

  always_comb begin
    lo_d   = lo_q;
    pend_d = 1'b0;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    fst_d  = 1'b0;
    if (load) begin
      vld_d  = 1'b1;
      dat_d  = dword[2*HALF_W-1:HALF_W];
      fst_d  = first_in;
      lo_d   = dword[HALF_W-1:0];
      pend_d = 1'b1;
    end else if (pend_q) begin
      vld_d  = 1'b1;
      dat_d  = lo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      fst_q  <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      fst_q  <= fst_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_first = fst_q;

  // R3
  lo_half_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ##2 out_valid);

  // R4
  first_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  // R3 (input spacing precondition)
  in_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid);

endmodule

// File: rtl/pktdec_frame.sv
module pktdec_frame
  import pktdec_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  dw_kind_e         kind,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             pkt_start,
  output logic             frame_err,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] mis_cnt,
  output logic [CNT_W-1:0] pkt_cnt
);

  localparam logic [LEN_W-1:0] LEN_MAX  = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_STEP = LEN_W'(2);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             open_q, open_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ferr_q, ferr_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic [CNT_W-1:0] mis_q, mis_d;
  logic [CNT_W-1:0] pkt_q, pkt_d;

  logic is_data, is_sep, is_bad, is_close;

  always_comb begin
    is_data  = in_valid && (kind == DW_DATA);
    is_sep   = in_valid && ((kind == DW_IDLE) || (kind == DW_OPCODE));
    is_bad   = in_valid && (kind == DW_BAD);
    is_close = is_sep && open_q;
  end

  always_comb begin
    open_d = open_q;
    len_d  = len_q;
    ferr_d = ferr_q;
    err_d  = err_q;
    mis_d  = mis_q;
    pkt_d  = pkt_q;
    if (is_data) begin
      open_d = 1'b1;
      if (!open_q) begin
        len_d = LEN_STEP;
        if (pkt_q != CNT_MAX) pkt_d = pkt_q + CNT_ONE;
      end else if (len_q >= LEN_MAX - LEN_STEP) begin
        len_d = LEN_MAX;
      end else begin
        len_d = len_q + LEN_STEP;
      end
    end
    if (is_sep) open_d = 1'b0;
    if (is_close && (len_q != cfg_len) && (mis_q != CNT_MAX)) mis_d = mis_q + CNT_ONE;
    if (is_bad) begin
      ferr_d = 1'b1;
      if (err_q != CNT_MAX) err_d = err_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      len_q  <= '0;
      ferr_q <= 1'b0;
      err_q  <= '0;
      mis_q  <= '0;
      pkt_q  <= '0;
    end else begin
      open_q <= open_d;
      len_q  <= len_d;
      ferr_q <= ferr_d;
      err_q  <= err_d;
      mis_q  <= mis_d;
      pkt_q  <= pkt_d;
    end
  end

  assign pkt_start = is_data && !open_q;
  assign frame_err = ferr_q;
  assign err_cnt   = err_q;
  assign mis_cnt   = mis_q;
  assign pkt_cnt   = pkt_q;

  // R6
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != $past(err_q)) |-> (err_q == $past(err_q) + CNT_ONE));

  // R7
  mis_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_q != $past(mis_q)) |-> (mis_q == $past(mis_q) + CNT_ONE));

  // R8
  pkt_only_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || (kind != DW_DATA)) |=> (pkt_q == $past(pkt_q)));

endmodule

// File: rtl/idle_frame_decoder.sv
module idle_frame_decoder
  import pktdec_pkg::*;
#(
  parameter int DW_W  = 32,
  parameter int LEN_W = 24,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DW_W-1:0]    in_data,
  input  logic [DW_W/8-1:0]  in_kflag,
  input  logic [LEN_W-1:0]   cfg_pkt_len,
  output logic               wrd_valid,
  output logic [DW_W/2-1:0]  wrd_data,
  output logic               wrd_first,
  output logic               op_valid,
  output logic [DW_W/2-1:0]  op_data,
  output logic               frame_err,
  output logic [CNT_W-1:0]   err_count,
  output logic [CNT_W-1:0]   len_mismatch_count,
  output logic [CNT_W-1:0]   pkt_count
);

  localparam int HALF_W = DW_W / 2;

  dw_kind_e kind;
  logic     pkt_start;
  logic     data_load;

  pktdec_classify u_classify (
    .dword (in_data),
    .kflag (in_kflag),
    .kind  (kind)
  );

  assign data_load = in_valid && (kind == DW_DATA);

  pktdec_split #(.HALF_W(HALF_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_load),
    .dword     (in_data),
    .first_in  (pkt_start),
    .in_valid  (in_valid),
    .out_valid (wrd_valid),
    .out_data  (wrd_data),
    .out_first (wrd_first)
  );

  pktdec_frame #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .kind      (kind),
    .cfg_len   (cfg_pkt_len),
    .pkt_start (pkt_start),
    .frame_err (frame_err),
    .err_cnt   (err_count),
    .mis_cnt   (len_mismatch_count),
    .pkt_cnt   (pkt_count)
  );

  logic              opv_q, opv_d;
  logic [HALF_W-1:0] opd_q, opd_d;

  always_comb begin
    opv_d = in_valid && (kind == DW_OPCODE);
    opd_d = opd_q;
    if (opv_d) opd_d = in_data[DW_W-9 -: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opv_q <= 1'b0;
      opd_q <= '0;
    end else begin
      opv_q <= opv_d;
      opd_q <= opd_d;
    end
  end

  assign op_valid = opv_q;
  assign op_data  = opd_q;

  // R5
  op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // R5
  op_excl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !wrd_first);

endmodule

// File: tb/idle_frame_decoder_tb_top.sv
module idle_frame_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [3:0]  in_kflag;
  logic [23:0] cfg_pkt_len;
  logic        wrd_valid;
  logic [15:0] wrd_data;
  logic        wrd_first;
  logic        op_valid;
  logic [15:0] op_data;
  logic        frame_err;
  logic [15:0] err_count;
  logic [15:0] len_mismatch_count;
  logic [15:0] pkt_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] IDLE = 32'hBC1CBC1C;

  always #2.5 clk = ~clk;

  idle_frame_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_kflag(in_kflag), .cfg_pkt_len(cfg_pkt_len), .wrd_valid(wrd_valid),
    .wrd_data(wrd_data), .wrd_first(wrd_first), .op_valid(op_valid),
    .op_data(op_data), .frame_err(frame_err), .err_count(err_count),
    .len_mismatch_count(len_mismatch_count), .pkt_count(pkt_count)
  );

  // sampled results of the last send
  logic        v0, f0, o0, v1, f1, o1;
  logic [15:0] d0, d1, od0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_kflag = k;
    @(posedge clk); #1;
    v0 = wrd_valid; d0 = wrd_data; f0 = wrd_first; o0 = op_valid; od0 = op_data;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; in_kflag = '0;
    @(posedge clk); #1;
    v1 = wrd_valid; d1 = wrd_data; f1 = wrd_first; o1 = op_valid;
  endtask

  task automatic test_reset();
    chk(wrd_valid, 0, "R1 wrd_valid");
    chk(wrd_first, 0, "R1 wrd_first");
    chk(op_valid, 0, "R1 op_valid");
    chk(frame_err, 0, "R1 frame_err");
    chk(err_count, 0, "R1 err_count");
    chk(len_mismatch_count, 0, "R1 len_mismatch_count");
    chk(pkt_count, 0, "R1 pkt_count");
  endtask

  task automatic test_idle();
    send(IDLE, 4'b1111);
    chk(v0, 0, "R2 idle no word e0");
    chk(v1, 0, "R2 idle no word e1");
    chk(o0, 0, "R2 idle no opcode");
    chk(frame_err, 0, "R2 idle not an error");
  endtask

  task automatic test_pkt_match();
    cfg_pkt_len = 24'd6;
    send(32'h1111_2222, 4'b0000);
    chk(v0, 1, "R3 hi valid");
    chk(d0, 16'h1111, "R3 hi data");
    chk(f0, 1, "R4 first on hi");
    chk(v1, 1, "R3 lo valid");
    chk(d1, 16'h2222, "R3 lo data");
    chk(f1, 0, "R4 no first on lo");
    chk(pkt_count, 1, "R8 pkt started");
    send(32'h3333_4444, 4'b0000);
    chk(d0, 16'h3333, "R3 hi data 2");
    chk(f0, 0, "R4 no first mid packet");
    chk(d1, 16'h4444, "R3 lo data 2");
    send(32'h5555_6666, 4'b0000);
    chk({d0, d1}, 32'h5555_6666, "R3 dword 3");
    send(IDLE, 4'b1111);
    chk(len_mismatch_count, 0, "R7 matching length");
    chk(pkt_count, 1, "R8 one packet");
  endtask

  task automatic test_pkt_short();
    send(32'hA0A1_A2A3, 4'b0000);
    chk(f0, 1, "R4 first after idle");
    send(32'hB0B1_B2B3, 4'b0000);
    send(IDLE, 4'b1111);
    chk(len_mismatch_count, 1, "R7 4 words vs 6");
    chk(pkt_count, 2, "R8 second packet");
    cfg_pkt_len = 24'd4;
    send(32'hC0C1_C2C3, 4'b0000);
    send(32'hD0D1_D2D3, 4'b0000);
    send(IDLE, 4'b1111);
    chk(len_mismatch_count, 1, "R7 4 words vs 4");
    chk(pkt_count, 3, "R8 third packet");
  endtask

  task automatic test_opcode();
    send(32'hFDAB_CD00, 4'b1000);
    chk(o0, 1, "R5 op_valid");
    chk(od0, 16'hABCD, "R5 op_data");
    chk(o1, 0, "R5 one-cycle pulse");
    chk(v0, 0, "R5 no word from opcode");
    send(32'h0102_0304, 4'b0000);
    chk(f0, 1, "R4 first after opcode");
    chk(pkt_count, 4, "R8 fourth packet");
    send(32'hFD12_3400, 4'b1000);
    chk(od0, 16'h1234, "R5 op_data 2");
    chk(len_mismatch_count, 2, "R7 opcode closes short packet");
    send(32'h0506_0708, 4'b0000);
    chk(f0, 1, "R4 first after closing opcode");
    send(IDLE, 4'b1111);
    chk(len_mismatch_count, 3, "R7 2 words vs 4");
    chk(pkt_count, 5, "R8 fifth packet");
  endtask

  task automatic test_bad();
    send(32'h1234_5678, 4'b0010);
    chk(v0, 0, "R6 bad dropped");
    chk(frame_err, 1, "R6 frame_err set");
    chk(err_count, 1, "R6 err_count 1");
    send(32'hBC1CBC1D, 4'b1111);
    chk(v0, 0, "R6 near-idle dropped");
    chk(err_count, 2, "R6 err_count 2");
    send(32'hFD11_2200, 4'b1001);
    chk(o0, 0, "R6 bad opcode no strobe");
    chk(err_count, 3, "R6 err_count 3");
    send(32'h7777_8888, 4'b0000);
    chk(f0, 1, "R4 first of packet");
    send(32'h9999_0000, 4'b0100);
    chk(v0, 0, "R6 bad in packet dropped");
    send(32'hAAAA_BBBB, 4'b0000);
    chk(f0, 0, "R4 bad word keeps packet open");
    chk(d1, 16'hBBBB, "R3 lo after bad");
    send(IDLE, 4'b1111);
    chk(len_mismatch_count, 3, "R7 bad word not counted in length");
    chk(frame_err, 1, "R6 frame_err sticky");
    chk(err_count, 4, "R6 err_count 4");
    chk(pkt_count, 6, "R8 sixth packet");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_kflag = '0;
    cfg_pkt_len = 24'd5000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    test_reset();
    test_idle();
    test_pkt_match();
    test_pkt_short();
    test_opcode();
    test_bad();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule